// File: doc/BRIEF.md
# UART Receive Flag Qualifier

This block sits behind a UART receiver's bit sampler. Each time the sampler finishes a character, it presents the byte and a set of side indications for one cycle: framing, parity and overrun errors, a break, whether an idle line came before the character, the received address bit, and an auto-baud break-plus-synch indication. The qualifier decides in that cycle whether the character is handed on. A character that is handed on is loaded into the receive buffer, raises the receive flag and records its status in sticky bits. A character that is filtered out leaves every output unchanged.

Five control inputs steer the decision. An error enable lets erroneous characters through. A break enable lets break characters through. A sleep enable filters out everything except addressed traffic. An auto-baud enable changes what counts as addressed traffic while sleeping. A soft-reset control holds the block cleared. Software clears the flag and the sticky status by pulsing the read strobe when it takes the buffer.

Top module: `uart_rx_qual`

## Requirements
- R1: After the asynchronous reset, or in the cycle after any edge where `softReset` is 1, `rxFlag`, `rxBuf` and all four status bits are 0. A `charDone` while `softReset` is 1 is not accepted.
- R2: When `errEn` is 0, a character whose `frameErr`, `parityErr` or `overrunIn` is 1 is discarded and does not set `rxFlag`.
- R3: When `errEn` is 1, an erroneous character is accepted. Its `frameErr`, `parityErr` and `overrunIn` are ORed into the sticky bits `stFrame`, `stParity` and `stOverrun`.
- R4: A character with `breakIn`=1 is accepted only when `brkEn` is 1, and it then sets the sticky bit `stBreak`.
- R5: When `sleepEn` is 0, every character that passes R2 and R4 is accepted. Accepting means that `rxFlag` is 1 and `rxBuf` holds the byte one clock edge after the `charDone` edge.
- R6: When `sleepEn` is 1 and `autoBaudEn` is 0, a character is accepted only if `idleBefore` or `addrBit` is 1.
- R7: When `sleepEn` is 1 and `autoBaudEn` is 1, a character is accepted only if `syncDet` is 1.
- R8: A `bufRead` pulse with no accepted character at the same edge clears `rxFlag` and all four status bits at that edge. `rxBuf` is left as it is.
- R9: If a character is accepted while `rxFlag` is 1 and `bufRead` is 0, then `stOverrun` is set, `rxBuf` takes the new byte and `rxFlag` stays 1.
- R10: A character that is not accepted leaves `rxBuf`, `rxFlag` and the status bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| softReset | input | 1 | Soft reset; clears and holds the block while 1 |
| errEn | input | 1 | Pass erroneous characters |
| brkEn | input | 1 | Pass break characters |
| sleepEn | input | 1 | Filter out all but addressed characters |
| autoBaudEn | input | 1 | While sleeping, accept only break-plus-synch |
| charDone | input | 1 | One-cycle strobe: a character has been received |
| charData | input | 8 | Received byte |
| frameErr | input | 1 | Framing error of this character |
| parityErr | input | 1 | Parity error of this character |
| overrunIn | input | 1 | Overrun reported by the receiver |
| breakIn | input | 1 | Character is a break |
| idleBefore | input | 1 | An idle line preceded the character |
| addrBit | input | 1 | Received address bit |
| syncDet | input | 1 | Break followed by a synch field was detected |
| bufRead | input | 1 | Software read of the buffer |
| rxFlag | output | 1 | Receive flag |
| rxBuf | output | 8 | Receive buffer |
| stFrame | output | 1 | Sticky framing error |
| stParity | output | 1 | Sticky parity error |
| stOverrun | output | 1 | Sticky overrun |
| stBreak | output | 1 | Sticky break |

## Verification
The assertions check on every cycle the properties that follow from one edge to the next. Soft reset drops the flag. A read with no new character drops it. A filtered character changes neither the buffer nor the flag. An accepted character that arrives while the flag is set marks overrun. The bench's scenarios are needed to show the full acceptance matrix: every combination of the error, break, sleep and auto-baud controls with matching character attributes. The scenarios also show that the buffer and status contents reach software through the read flow, and that status is cleared by a read.

// File: rtl/uart_rx_qual_pkg.sv
package uart_rx_qual_pkg;
  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic load;     // accept the current character
    logic clear;    // software read of the buffer
    logic wipe;     // soft reset
    logic overrun;  // accepted while the flag was still set
  } rxq_strobe_t;
endpackage

// File: rtl/uart_rx_qual_ctrl.sv
module uart_rx_qual_ctrl
  import uart_rx_qual_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        softReset,
  input  logic        errEn,
  input  logic        brkEn,
  input  logic        sleepEn,
  input  logic        autoBaudEn,
  input  logic        charDone,
  input  logic        frameErr,
  input  logic        parityErr,
  input  logic        overrunIn,
  input  logic        breakIn,
  input  logic        idleBefore,
  input  logic        addrBit,
  input  logic        syncDet,
  input  logic        bufRead,
  output logic        rxFlag,
  output rxq_strobe_t strobes
);
  logic anyErr, errPass, brkPass, addrPass, sleepPass, accept;

  always_comb begin
    anyErr    = frameErr | parityErr | overrunIn;
    errPass   = !anyErr || errEn;
    brkPass   = !breakIn || brkEn;
    addrPass  = autoBaudEn ? syncDet : (idleBefore | addrBit);
    sleepPass = !sleepEn || addrPass;
    accept    = charDone && !softReset && errPass && brkPass && sleepPass;
  end

  always_comb begin
    strobes.load    = accept;
    strobes.clear   = bufRead && !softReset;
    strobes.wipe    = softReset;
    strobes.overrun = accept && rxFlag && !bufRead;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rxFlag <= 1'b0;
    else if (softReset)  rxFlag <= 1'b0;
    else if (accept)     rxFlag <= 1'b1;
    else if (bufRead)    rxFlag <= 1'b0;
  end

  // R1: soft reset drops the flag
  a_r1_soft_reset_flag: assert property (@(posedge clk) disable iff (!rst_n)
    softReset |=> !rxFlag);
  // R2: discarded erroneous character leaves a clear flag clear
  a_r2_err_discard: assert property (@(posedge clk) disable iff (!rst_n)
    (charDone && !errEn && (frameErr || parityErr || overrunIn) && !rxFlag) |=> !rxFlag);
  // R7: sleeping auto-baud without synch does not raise the flag
  a_r7_sync_only: assert property (@(posedge clk) disable iff (!rst_n)
    (charDone && sleepEn && autoBaudEn && !syncDet && !rxFlag) |=> !rxFlag);
  // R8: a read with no new character clears the flag
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bufRead && !charDone) |=> !rxFlag);
endmodule

// File: rtl/uart_rx_qual_dp.sv
module uart_rx_qual_dp
  import uart_rx_qual_pkg::*;
#(
  parameter int DataWidth = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  rxq_strobe_t          strobes,
  input  logic [DataWidth-1:0] charData,
  input  logic                 frameErr,
  input  logic                 parityErr,
  input  logic                 overrunIn,
  input  logic                 breakIn,
  output logic [DataWidth-1:0] rxBuf,
  output logic                 stFrame,
  output logic                 stParity,
  output logic                 stOverrun,
  output logic                 stBreak
);
  localparam int StatW = 4;
  logic [StatW-1:0] stat, statBase, statNew;

  // A read at the same edge as a load drops the old status first
  assign statBase = strobes.clear ? '0 : stat;
  assign statNew  = {breakIn, overrunIn | strobes.overrun, parityErr, frameErr};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxBuf <= '0;
      stat  <= '0;
    end else if (strobes.wipe) begin
      rxBuf <= '0;
      stat  <= '0;
    end else if (strobes.load) begin
      rxBuf <= charData;
      stat  <= statBase | statNew;
    end else if (strobes.clear) begin
      stat  <= '0;
    end
  end

  assign stFrame   = stat[0];
  assign stParity  = stat[1];
  assign stOverrun = stat[2];
  assign stBreak   = stat[3];

  // R10: buffer holds when nothing is loaded or wiped
  a_r10_buf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobes.load && !strobes.wipe) |=> $stable(rxBuf));
  // R8: a read without a load empties the status
  a_r8_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.clear && !strobes.load && !strobes.wipe) |=> (stat == '0));
endmodule

// File: rtl/uart_rx_qual.sv
module uart_rx_qual
  import uart_rx_qual_pkg::*;
#(
  parameter int DataWidth = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 softReset,
  input  logic                 errEn,
  input  logic                 brkEn,
  input  logic                 sleepEn,
  input  logic                 autoBaudEn,
  input  logic                 charDone,
  input  logic [DataWidth-1:0] charData,
  input  logic                 frameErr,
  input  logic                 parityErr,
  input  logic                 overrunIn,
  input  logic                 breakIn,
  input  logic                 idleBefore,
  input  logic                 addrBit,
  input  logic                 syncDet,
  input  logic                 bufRead,
  output logic                 rxFlag,
  output logic [DataWidth-1:0] rxBuf,
  output logic                 stFrame,
  output logic                 stParity,
  output logic                 stOverrun,
  output logic                 stBreak
);
  rxq_strobe_t strobes;

  uart_rx_qual_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .softReset(softReset), .errEn(errEn),
    .brkEn(brkEn), .sleepEn(sleepEn), .autoBaudEn(autoBaudEn),
    .charDone(charDone), .frameErr(frameErr), .parityErr(parityErr),
    .overrunIn(overrunIn), .breakIn(breakIn), .idleBefore(idleBefore),
    .addrBit(addrBit), .syncDet(syncDet), .bufRead(bufRead),
    .rxFlag(rxFlag), .strobes(strobes)
  );

  uart_rx_qual_dp #(.DataWidth(DataWidth)) i_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .charData(charData),
    .frameErr(frameErr), .parityErr(parityErr), .overrunIn(overrunIn),
    .breakIn(breakIn), .rxBuf(rxBuf), .stFrame(stFrame),
    .stParity(stParity), .stOverrun(stOverrun), .stBreak(stBreak)
  );

  // R9: accepted while the flag is pending marks overrun and keeps the flag
  a_r9_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.load && rxFlag && !bufRead) |=> (stOverrun && rxFlag));
endmodule

// File: tb/test_uart_rx_qual.sv
module test_uart_rx_qual;
  typedef struct {
    logic [7:0] data;
    logic fe, pe, oe, brk;
    string tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic softReset = 1'b1;
  logic errEn = 0, brkEn = 0, sleepEn = 0, autoBaudEn = 0;
  logic charDone = 0;
  logic [7:0] charData = '0;
  logic frameErr = 0, parityErr = 0, overrunIn = 0, breakIn = 0;
  logic idleBefore = 0, addrBit = 0, syncDet = 0;
  logic monRead = 0, manRead = 0, bufRead;
  logic rxFlag, stFrame, stParity, stOverrun, stBreak;
  logic [7:0] rxBuf;

  int checks = 0, errors = 0;
  bit autoRead = 1'b1;
  bit finished = 1'b0;
  logic [7:0] lastBuf = '0;
  item_t expQ[$];

  assign bufRead = monRead | manRead;
  always #4 clk = ~clk;  // 125 MHz

  uart_rx_qual i_uart_rx_qual (
    .clk(clk), .rst_n(rst_n), .softReset(softReset), .errEn(errEn),
    .brkEn(brkEn), .sleepEn(sleepEn), .autoBaudEn(autoBaudEn),
    .charDone(charDone), .charData(charData), .frameErr(frameErr),
    .parityErr(parityErr), .overrunIn(overrunIn), .breakIn(breakIn),
    .idleBefore(idleBefore), .addrBit(addrBit), .syncDet(syncDet),
    .bufRead(bufRead), .rxFlag(rxFlag), .rxBuf(rxBuf), .stFrame(stFrame),
    .stParity(stParity), .stOverrun(stOverrun), .stBreak(stBreak)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Monitor: consume flagged characters and compare to the scoreboard
  always @(negedge clk) begin
    if (monRead) monRead <= 1'b0;
    else if (autoRead && rxFlag && rst_n) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10 unexpected flag: actual 1 expected 0");
      end else begin
        item_t it;
        it = expQ.pop_front();
        check(it.tag, "rxBuf", rxBuf, it.data);
        check(it.tag, "stFrame", stFrame, it.fe);
        check(it.tag, "stParity", stParity, it.pe);
        check(it.tag, "stOverrun", stOverrun, it.oe);
        check(it.tag, "stBreak", stBreak, it.brk);
      end
      monRead <= 1'b1;
    end
  end

  // Driver: present one character, predict acceptance from the requirements
  task automatic sendChar(input string tag, input logic [7:0] d,
                          input logic fe, input logic pe, input logic oe,
                          input logic brk, input logic idle, input logic addr,
                          input logic sy);
    bit acc;
    item_t it;
    acc = !softReset && (!(fe | pe | oe) || errEn) && (!brk || brkEn) &&
          (!sleepEn || (autoBaudEn ? sy : (idle | addr)));
    if (acc && autoRead) begin
      it.data = d; it.fe = fe; it.pe = pe; it.oe = oe; it.brk = brk; it.tag = tag;
      expQ.push_back(it);
    end
    @(negedge clk);
    charDone = 1; charData = d; frameErr = fe; parityErr = pe; overrunIn = oe;
    breakIn = brk; idleBefore = idle; addrBit = addr; syncDet = sy;
    @(negedge clk);
    charDone = 0; frameErr = 0; parityErr = 0; overrunIn = 0; breakIn = 0;
    idleBefore = 0; addrBit = 0; syncDet = 0;
    if (acc) lastBuf = d;
    else if (autoRead) begin
      check(tag, "filtered flag", rxFlag, 0);
      check(tag, "filtered rxBuf (R10)", rxBuf, lastBuf);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic manualRead();
    @(negedge clk); manRead = 1;
    @(negedge clk); manRead = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state (soft reset still 1)
    check("R1", "flag after reset", rxFlag, 0);
    check("R1", "rxBuf after reset", rxBuf, 0);
    check("R1", "status after reset", {stFrame, stParity, stOverrun, stBreak}, 0);
    sendChar("R1", 8'h77, 0, 0, 0, 0, 0, 0, 0);
    softReset = 0;

    // R5 plain characters, awake
    sendChar("R5", 8'hA5, 0, 0, 0, 0, 0, 0, 0);
    sendChar("R5", 8'h3C, 0, 0, 0, 0, 1, 0, 0);

    // R2 errors discarded
    sendChar("R2", 8'h11, 1, 0, 0, 0, 0, 0, 0);
    sendChar("R2", 8'h12, 0, 1, 0, 0, 0, 0, 0);
    sendChar("R2", 8'h13, 0, 0, 1, 0, 0, 0, 0);

    // R3 errors passed
    errEn = 1;
    sendChar("R3", 8'h21, 1, 0, 0, 0, 0, 0, 0);
    sendChar("R3", 8'h22, 0, 1, 0, 0, 0, 0, 0);
    sendChar("R3", 8'h23, 0, 0, 1, 0, 0, 0, 0);
    errEn = 0;

    // R4 breaks
    sendChar("R4", 8'h00, 0, 0, 0, 1, 0, 0, 0);
    brkEn = 1;
    sendChar("R4", 8'h00, 0, 0, 0, 1, 0, 0, 0);
    brkEn = 0;

    // R6 sleeping, address by idle or address bit
    sleepEn = 1;
    sendChar("R6", 8'h31, 0, 0, 0, 0, 0, 0, 0);
    sendChar("R6", 8'h32, 0, 0, 0, 0, 1, 0, 0);
    sendChar("R6", 8'h33, 0, 0, 0, 0, 0, 1, 0);

    // R7 sleeping with auto-baud: only break plus synch
    autoBaudEn = 1;
    sendChar("R7", 8'h41, 0, 0, 0, 0, 1, 1, 0);
    sendChar("R7", 8'h55, 0, 0, 0, 0, 0, 0, 1);
    autoBaudEn = 0; sleepEn = 0;

    // R9 overrun with no read in between
    autoRead = 0;
    sendChar("R9", 8'h61, 0, 0, 0, 0, 0, 0, 0);
    sendChar("R9", 8'h62, 0, 0, 0, 0, 0, 0, 0);
    check("R9", "flag kept", rxFlag, 1);
    check("R9", "rxBuf overwritten", rxBuf, 8'h62);
    check("R9", "stOverrun", stOverrun, 1);
    // R10 with a pending flag: filtered character leaves all unchanged
    sendChar("R10", 8'h63, 1, 0, 0, 0, 0, 0, 0);
    check("R10", "rxBuf held", rxBuf, 8'h62);
    check("R10", "flag held", rxFlag, 1);
    check("R10", "stFrame held", stFrame, 0);

    // R8 read clears flag and status, buffer kept
    manualRead();
    check("R8", "flag cleared", rxFlag, 0);
    check("R8", "stOverrun cleared", stOverrun, 0);
    check("R8", "rxBuf kept", rxBuf, 8'h62);

    // R1 soft reset clears a pending character
    sendChar("R1", 8'h71, 0, 0, 0, 0, 0, 0, 0);
    check("R1", "flag pending", rxFlag, 1);
    @(negedge clk); softReset = 1;
    @(negedge clk);
    check("R1", "flag after soft reset", rxFlag, 0);
    check("R1", "rxBuf after soft reset", rxBuf, 0);

    check("R10", "scoreboard drained", expQ.size(), 0);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule